// File: doc/BRIEF.md
# Register Group Transfer Sequencer

This block moves a group of 32-bit general registers between the register file and a word-wide memory, one word per cycle. A one-cycle start pulse selects one of two fixed range rules. In window mode the group is always registers 4 to 7, and the base address comes from the register that the 4-bit operand names. In sweep mode the group runs from the register index given by the operand up to register 15, and the base address always comes from register 0.

The direction input chooses between load, where memory words are written into registers, and store, where register values are written to memory. The address goes up by four for each word. Each word is accepted in a cycle where the memory ready input is high. While ready is low the sequencer waits and changes nothing. After the last word it raises a done pulse for one cycle. A count output shows how many memory operations the sequence has made. The base register is never given a final address.

Top module: `regblk_mover`

## Requirements
- R1: After reset `busy_o`, `done_o`, `mem_req_o`, `rf_wr_en_o` are 0 and `memop_count_o` is 0.
- R2: With `mode_sweep_i`=0 (window mode) the sequence touches registers 4, 5, 6, 7 in that order, for any value of `operand_i`.
- R3: In window mode the first address is the value of the register indexed by `operand_i`. Each accepted word raises the address by 4.
- R4: With `mode_sweep_i`=1 (sweep mode) the first address is the value of register 0. The registers touched run from `operand_i` up to 15 inclusive, in ascending order, with the address rising by 4 per word.
- R5: When `done_o` is high, `memop_count_o` equals 16 minus `operand_i` in sweep mode and 4 in window mode.
- R6: With `dir_load_i`=1 each accepted word writes `mem_rdata_i` into the current register through `rf_wr_en_o`/`rf_wr_idx_o`/`rf_wr_data_o`, with `mem_we_o`=0. With `dir_load_i`=0 it drives `mem_we_o`=1 and `mem_wdata_o` equal to the current register value, and makes no register write.
- R7: `done_o` is high for exactly one cycle, in the cycle after the cycle in which the last word was accepted, and `busy_o` is 0 in that cycle.
- R8: While `mem_req_o` is 1 and `mem_ready_i` is 0, the address and the register index hold, and no register write takes place.
- R9: A start pulse while a sequence is running is ignored: the running sequence keeps its mode, direction, range and addresses.
- R10: A sequence writes no register outside its transfer range. In particular the base register is not updated with a final address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, used only when idle |
| mode_sweep_i | input | 1 | 0 = window mode (regs 4..7), 1 = sweep mode (start..15, base r0) |
| dir_load_i | input | 1 | 1 = load memory into registers, 0 = store registers to memory |
| operand_i | input | 4 | Window mode: base register index; sweep mode: first register index |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last word |
| memop_count_o | output | 5 | Memory operations made by the current or last sequence |
| rf_rd_idx_o | output | 4 | Register-file read index (base register when idle) |
| rf_rd_data_i | input | 32 | Register-file read data, combinational |
| rf_wr_en_o | output | 1 | Register-file write enable |
| rf_wr_idx_o | output | 4 | Register-file write index |
| rf_wr_data_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory word access request |
| mem_we_o | output | 1 | Memory write (store) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory accepts the word this cycle |

## Verification
The bench builds the block with its default parameters: sixteen 32-bit registers, a four-register window starting at register 4, and a 5-bit count. This covers the sweep extremes: start index 0, where register 0 is both the base and the first register loaded, and start index 15, a single word. It also covers a window-mode base register that lies inside the window itself. Random ready patterns stretch each sequence through stalls of varying length. Starts issued mid-sequence with the opposite mode and direction test that such pulses are ignored.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    localparam int unsigned BYTES_PER_WORD = 4;

endpackage

// File: rtl/rbm_range.sv
module rbm_range #(
    parameter int unsigned NREG       = 16,
    parameter int unsigned QUAD_FIRST = 4,
    parameter int unsigned QUAD_CNT   = 4,
    parameter int unsigned IDX_W      = $clog2(NREG)
) (
    input  logic             mode_sweep_i,
    input  logic [IDX_W-1:0] operand_i,
    output logic [IDX_W-1:0] base_idx_o,
    output logic [IDX_W-1:0] first_idx_o,
    output logic [IDX_W-1:0] last_idx_o
);
    localparam logic [IDX_W-1:0] SWEEP_LAST = IDX_W'(NREG - 1);
    localparam logic [IDX_W-1:0] WIN_FIRST  = IDX_W'(QUAD_FIRST);
    localparam logic [IDX_W-1:0] WIN_LAST   = IDX_W'(QUAD_FIRST + QUAD_CNT - 1);
    localparam logic [IDX_W-1:0] SWEEP_BASE = '0;

    always_comb begin
        if (mode_sweep_i) begin
            base_idx_o  = SWEEP_BASE;
            first_idx_o = operand_i;
            last_idx_o  = SWEEP_LAST;
        end else begin
            base_idx_o  = operand_i;
            first_idx_o = WIN_FIRST;
            last_idx_o  = WIN_LAST;
        end
    end

    always_comb begin
        assert (first_idx_o <= last_idx_o); // R4
    end
endmodule

// File: rtl/rbm_engine.sv
module rbm_engine #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned NREG       = 16,
    parameter int unsigned QUAD_FIRST = 4,
    parameter int unsigned QUAD_CNT   = 4,
    parameter int unsigned IDX_W      = $clog2(NREG),
    parameter int unsigned CNT_W      = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_sweep_i,
    input  logic              dir_load_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [IDX_W-1:0]  first_idx_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic [DATA_W-1:0] reg_val_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [IDX_W-1:0]  cur_idx_o,
    output logic [CNT_W-1:0]  memop_count_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              rf_wr_en_o,
    output logic [IDX_W-1:0]  rf_wr_idx_o,
    output logic [DATA_W-1:0] rf_wr_data_o
);
    import rbm_pkg::*;

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BYTES_PER_WORD);

    typedef struct packed {
        seq_state_e        st;
        logic              sweep;
        logic              load;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [CNT_W-1:0]  cnt;
        logic              done;
    } eng_s;

    eng_s seq_d, seq_q;
    logic accept;

    assign accept = (seq_q.st == SEQ_RUN) && mem_ready_i;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    seq_d.st    = SEQ_RUN;
                    seq_d.sweep = mode_sweep_i;
                    seq_d.load  = dir_load_i;
                    seq_d.addr  = base_addr_i;
                    seq_d.idx   = first_idx_i;
                    seq_d.last  = last_idx_i;
                    seq_d.cnt   = '0;
                end
            end
            SEQ_RUN: begin
                if (mem_ready_i) begin
                    seq_d.addr = seq_q.addr + ADDR_STEP;
                    seq_d.cnt  = seq_q.cnt + CNT_W'(1);
                    if (seq_q.idx == seq_q.last) begin
                        seq_d.st   = SEQ_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.idx = seq_q.idx + IDX_W'(1);
                    end
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, sweep: 1'b0, load: 1'b0, addr: '0,
                       idx: '0, last: '0, cnt: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o        = (seq_q.st == SEQ_RUN);
    assign done_o        = seq_q.done;
    assign cur_idx_o     = seq_q.idx;
    assign memop_count_o = seq_q.cnt;
    assign mem_req_o     = busy_o;
    assign mem_we_o      = busy_o && !seq_q.load;
    assign mem_addr_o    = seq_q.addr;
    assign mem_wdata_o   = reg_val_i;
    assign rf_wr_en_o    = accept && seq_q.load;
    assign rf_wr_idx_o   = seq_q.idx;
    assign rf_wr_data_o  = mem_rdata_i;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_ready_i) |=> ($stable(mem_addr_o) && $stable(cur_idx_o))); // R8
    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_ready_i) |-> !rf_wr_en_o); // R8
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !seq_d.done) |=> (mem_addr_o == $past(mem_addr_o) + ADDR_STEP)); // R3
    AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && busy_o && !seq_d.done) |=> (cur_idx_o == $past(cur_idx_o) + IDX_W'(1))); // R4
    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !seq_q.sweep) |-> (int'(cur_idx_o) >= int'(QUAD_FIRST) &&
                                      int'(cur_idx_o) < int'(QUAD_FIRST + QUAD_CNT))); // R2
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(memop_count_o) <= int'(NREG)); // R5
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(seq_q.load) && $stable(seq_q.sweep))); // R9
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rf_wr_en_o); // R10
endmodule

// File: rtl/regblk_mover.sv
module regblk_mover #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned NREG       = 16,
    parameter int unsigned QUAD_FIRST = 4,
    parameter int unsigned QUAD_CNT   = 4,
    parameter int unsigned IDX_W      = $clog2(NREG),
    parameter int unsigned CNT_W      = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_sweep_i,
    input  logic              dir_load_i,
    input  logic [IDX_W-1:0]  operand_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  memop_count_o,
    output logic [IDX_W-1:0]  rf_rd_idx_o,
    input  logic [DATA_W-1:0] rf_rd_data_i,
    output logic              rf_wr_en_o,
    output logic [IDX_W-1:0]  rf_wr_idx_o,
    output logic [DATA_W-1:0] rf_wr_data_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i
);
    logic [IDX_W-1:0]  base_idx, first_idx, last_idx, cur_idx;
    logic [ADDR_W-1:0] base_addr;

    rbm_range #(
        .NREG(NREG), .QUAD_FIRST(QUAD_FIRST), .QUAD_CNT(QUAD_CNT), .IDX_W(IDX_W)
    ) u_range (
        .mode_sweep_i(mode_sweep_i),
        .operand_i   (operand_i),
        .base_idx_o  (base_idx),
        .first_idx_o (first_idx),
        .last_idx_o  (last_idx)
    );

    generate
        if (ADDR_W <= DATA_W) begin : g_addr_trunc
            assign base_addr = rf_rd_data_i[ADDR_W-1:0];
        end else begin : g_addr_ext
            assign base_addr = {{(ADDR_W-DATA_W){1'b0}}, rf_rd_data_i};
        end
    endgenerate

    rbm_engine #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG), .QUAD_FIRST(QUAD_FIRST),
        .QUAD_CNT(QUAD_CNT), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_sweep_i (mode_sweep_i),
        .dir_load_i   (dir_load_i),
        .base_addr_i  (base_addr),
        .first_idx_i  (first_idx),
        .last_idx_i   (last_idx),
        .mem_ready_i  (mem_ready_i),
        .mem_rdata_i  (mem_rdata_i),
        .reg_val_i    (rf_rd_data_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .cur_idx_o    (cur_idx),
        .memop_count_o(memop_count_o),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .rf_wr_en_o   (rf_wr_en_o),
        .rf_wr_idx_o  (rf_wr_idx_o),
        .rf_wr_data_o (rf_wr_data_o)
    );

    assign rf_rd_idx_o = busy_o ? cur_idx : base_idx;

    AST_RD_BASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && mode_sweep_i) |-> (rf_rd_idx_o == '0)); // R4
endmodule

// File: tb/test_regblk_mover.sv
module test_regblk_mover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, mode = 1'b0, dir = 1'b0, ready = 1'b0;
    logic [3:0]  operand = '0;
    logic        busy, done, rf_wr_en, mem_req, mem_we;
    logic [4:0]  cnt;
    logic [3:0]  rf_rd_idx, rf_wr_idx;
    logic [31:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata, mem_rdata;

    logic [31:0] rf [16];
    logic [31:0] mem [64];
    logic [31:0] exp_rf [16];
    logic [31:0] exp_mem [64];
    logic        pl_en = 1'b0;
    logic [3:0]  pl_idx = '0;
    logic [31:0] pl_data = '0;
    int nchk = 0, nfail = 0;

    always #5 clk = ~clk;

    regblk_mover i_regblk_mover (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_sweep_i(mode),
        .dir_load_i(dir), .operand_i(operand), .busy_o(busy), .done_o(done),
        .memop_count_o(cnt), .rf_rd_idx_o(rf_rd_idx), .rf_rd_data_i(rf_rd_data),
        .rf_wr_en_o(rf_wr_en), .rf_wr_idx_o(rf_wr_idx), .rf_wr_data_o(rf_wr_data),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(ready)
    );

    function automatic logic [31:0] mem_init(input int i);
        return 32'hC3000000 ^ (32'(i) * 32'h00010203);
    endfunction

    assign rf_rd_data = rf[rf_rd_idx];
    assign mem_rdata  = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) rf[i] <= '0;
            for (int i = 0; i < 64; i++) mem[i] <= mem_init(i);
        end else begin
            if (pl_en) rf[pl_idx] <= pl_data;
            else if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;
            if (mem_req && ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic set_reg(input int idx, input logic [31:0] val);
        @(negedge clk);
        pl_en = 1'b1; pl_idx = 4'(idx); pl_data = val;
        exp_rf[idx] = val;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic run_op(input bit sweep, input bit load, input logic [3:0] opnd,
                          input bit hammer, input int rdy_pct);
        logic [31:0] base, addr;
        int first, n, k, guard, eidx, midx;
        bit seq_ok;
        base  = sweep ? exp_rf[0] : exp_rf[opnd];
        first = sweep ? int'(opnd) : 4;
        n     = sweep ? 16 - int'(opnd) : 4;
        @(negedge clk);
        start = 1'b1; mode = sweep; dir = load; operand = opnd;
        @(negedge clk);
        start = hammer; mode = ~sweep; dir = ~load; operand = ~opnd;
        k = 0; guard = 0; seq_ok = 1'b1;
        while (k < n && guard < 2000) begin
            ready = ($urandom % 100) < rdy_pct;
            #1;
            if (!mem_req) seq_ok = 1'b0;
            if (ready && mem_req) begin
                eidx = first + k;
                addr = base + 32'(4 * k);
                midx = int'(addr[7:2]);
                chk(mem_addr == addr, sweep ? "R4 address" : "R3 address", mem_addr, addr);
                if (load) begin
                    chk(rf_wr_en && !mem_we && rf_wr_idx == 4'(eidx),
                        sweep ? "R4 R6 load index" : "R2 R6 load index",
                        {27'd0, rf_wr_en, rf_wr_idx}, {28'd1, 4'(eidx)});
                    chk(rf_wr_data == exp_mem[midx], "R6 load data", rf_wr_data, exp_mem[midx]);
                    exp_rf[eidx] = exp_mem[midx];
                end else begin
                    chk(mem_we && !rf_wr_en && rf_rd_idx == 4'(eidx),
                        sweep ? "R4 R6 store index" : "R2 R6 store index",
                        {27'd0, mem_we, rf_rd_idx}, {28'd1, 4'(eidx)});
                    chk(mem_wdata == exp_rf[eidx], "R6 store data", mem_wdata, exp_rf[eidx]);
                    exp_mem[midx] = exp_rf[eidx];
                end
                k++;
            end else if (mem_req) begin
                eidx = first + k;
                addr = base + 32'(4 * k);
                chk(!rf_wr_en && !done && mem_addr == addr, "R8 stall hold", mem_addr, addr);
            end
            @(negedge clk);
            start = 1'b0;
            guard++;
        end
        chk(seq_ok, "R9 request held through sequence", 32'(seq_ok), 32'd1);
        ready = 1'b0;
        #1;
        chk(done && !busy, "R7 done pulse", {30'd0, done, busy}, 32'd2);
        chk(cnt == 5'(n), "R5 memop count", 32'(cnt), 32'(n));
        @(negedge clk);
        #1;
        chk(!done, "R7 done single cycle", 32'(done), 32'd0);
        for (int i = 0; i < 16; i++)
            if (rf[i] !== exp_rf[i]) chk(1'b0, "R10 register file", rf[i], exp_rf[i]);
        chk(1'b1, "R10 register file", 0, 0);
        for (int i = 0; i < 64; i++)
            if (mem[i] !== exp_mem[i]) chk(1'b0, "R6 memory image", mem[i], exp_mem[i]);
    endtask

    initial begin
        #(10 * 150000);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) exp_rf[i] = '0;
        for (int i = 0; i < 64; i++) exp_mem[i] = mem_init(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!busy && !done && !mem_req && !rf_wr_en && cnt == 0, "R1 reset state",
            {27'd0, busy, done, mem_req, rf_wr_en, 1'b0}, 32'd0);
        chk(cnt == 0, "R1 reset count", 32'(cnt), 32'd0);

        // directed corners
        for (int i = 0; i < 16; i++) set_reg(i, 32'h10000000 * 32'(i) + 32'(i * 20));
        run_op(1'b0, 1'b1, 4'd5, 1'b0, 100);   // R2 base inside window
        run_op(1'b0, 1'b0, 4'd12, 1'b1, 60);   // R3 R9
        set_reg(0, 32'h00000040);
        run_op(1'b1, 1'b0, 4'd15, 1'b0, 100);  // R4 single word
        set_reg(0, 32'h00000000);
        run_op(1'b1, 1'b1, 4'd0, 1'b1, 50);    // R4 R10 base loaded first
        set_reg(0, 32'h000000F8);
        run_op(1'b1, 1'b0, 4'd1, 1'b0, 30);    // R8 heavy stalls, address wrap in bench memory
        run_op(1'b0, 1'b0, 4'd0, 1'b1, 30);    // R2 base r0 in window mode

        // random mix
        for (int t = 0; t < 40; t++) begin
            set_reg(0, $urandom);
            set_reg(int'($urandom % 16), $urandom);
            run_op(1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom),
                   30 + int'($urandom % 71));
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule